// File: doc/BRIEF.md
# Multi-Domain Reset Sequencing Controller

This controller turns register writes into timed reset pulses for three domains of a small networking device. The host domain covers the host bus interface, the host MAC (including its latched transmit and receive error flags) and the system control registers below address 0x100. Each of the two PHY ports is its own domain. Software starts a reset by writing 1 to a bit of the reset control word. The bit reads back as 1 while its reset runs and returns to 0 by itself when the reset ends, so software can poll for completion.

A host (soft) reset drives the host reset line for a fixed time. It then starts the configuration loader in a restricted mode that reloads only the MAC address. The loader window depends on the loader bus type and ends early when the loader reports done. A soft reset never re-samples the configuration straps. That happens only once, when the power-on reset is released.

A PHY reset can be requested through the reset control word or through the reset bit of that PHY's control register. It lasts a fixed time and touches no other domain. When a PHY leaves power-down, the PHY gets an automatic reset that keeps its register contents. All durations are given in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `rst_seq_ctrl`

## Requirements
- R1: A write with wrData bit 0 set, while no soft reset is running, raises hostRst in the next cycle. hostRst stays high for exactly SOFT_US*CYC_PER_US cycles.
- R2: In the cycle after hostRst falls, ldrStart is high for one cycle. ldrMacOnly is high from that cycle until the loader phase ends, and only then.
- R3: The loader phase ends in the cycle after ldrDone is sampled high. If ldrDone does not come, it ends after LDR_2W_US*CYC_PER_US cycles when ldrTwoWire was 1 at loader start, or after LDR_3W_US*CYC_PER_US cycles when it was 0.
- R4: strapLatch is high only while rstN is low and up to the first clock edge after its release. A soft reset never raises it.
- R5: For port i, a write with wrData bit i+1 set, or a pulse on phyCtlReq[i], raises phyRst[i] in the next cycle for exactly PHY_US*CYC_PER_US cycles. No other reset output and no loader start follows from it.
- R6: phyCtlRstBit[i] is high during a port-i reset that phyCtlReq[i] started. At the end of that reset it clears in the same cycle as rdData bit i+1.
- R7: A high-to-low change on phyPwrDn[i] starts a port-i reset of the same length with phyRegClr[i] low (registers kept). A register-initiated reset holds phyRegClr[i] high, and the register path wins when both happen in one cycle.
- R8: A request for a domain whose reset is running has no effect on that reset's length or mode. Requests for different domains run at the same time and are timed independently.
- R9: rdData bit 0 reads 1 while the soft reset (host or loader phase) runs, and rdData bit i+1 reads 1 while phyRst[i] is high. Writing 0 to a bit starts nothing and stops nothing.
- R10: After reset release all reset outputs, ldrStart, ldrMacOnly and rdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Write strobe for the reset control word |
| wrData | input | 3 | Bit 0 requests a soft reset; bit i+1 requests a reset of PHY port i |
| rdData | output | 3 | Reset-in-progress flags, same bit layout as wrData |
| phyCtlReq | input | 2 | Per-port pulse: reset bit written in that PHY's control register |
| phyPwrDn | input | 2 | Per-port PHY power-down level |
| phyRst | output | 2 | Per-port PHY reset |
| phyRegClr | output | 2 | High with phyRst when the PHY registers are to be reset |
| phyCtlRstBit | output | 2 | Readback of the PHY control register reset bit |
| hostRst | output | 1 | Host interface, host MAC, error flags and low system registers reset |
| strapLatch | output | 1 | Configuration strap sampling enable |
| ldrStart | output | 1 | One-cycle loader start pulse |
| ldrMacOnly | output | 1 | Loader restricted to the MAC address; high during the loader phase |
| ldrTwoWire | input | 1 | Loader bus type: 1 two-wire serial, 0 three-wire |
| ldrDone | input | 1 | Loader completion pulse |

## Verification
The bench targets a few risky cases. A second soft-reset write lands in the middle of the host phase; a design that restarted its counter would stretch hostRst. A PHY reset is re-requested by both paths while it runs, and a power-down exit arrives on a busy port; a design that reloaded or re-moded would change the pulse length or drop phyRegClr. The loader window runs once with an early done and once timing out on the three-wire bus; a design that picked the wrong window, or ignored done, would hold ldrMacOnly and rdData bit 0 for the wrong time. A power-down exit in the same cycle as a control-register request shows whether register clearing wins, and a write of all three bits shows whether the three domains run independently.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Number of PHY ports handled by the controller.
  parameter int PHY_PORTS = 2;

  typedef enum logic [1:0] {
    SOFT_IDLE = 2'd0,
    SOFT_HOST = 2'd1,
    SOFT_LOAD = 2'd2
  } softPhaseT;

  // Strobes from control to the timing datapath.
  typedef struct packed {
    logic                 hostLoad;  // load the host-phase duration
    logic                 ldrLoad;   // load the loader window
    logic                 softDec;   // count down the soft counter
    logic [PHY_PORTS-1:0] phyLoad;   // load a PHY reset duration
    logic [PHY_PORTS-1:0] phyDec;    // count down a PHY counter
  } seqStrobeT;

endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int SOFT_CYC = 590,
  parameter int LDR2_CYC = 550,
  parameter int LDR3_CYC = 170,
  parameter int PHY_CYC  = 110,
  parameter int CNT_W    = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobeT            strobe,
  input  logic                 ldrTwoWire,
  output logic                 softZero,
  output logic [PHY_PORTS-1:0] phyZero
);

  logic [CNT_W-1:0] softCnt;

  // One counter serves both soft phases, reloaded at each phase entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softCnt <= '0;
    end else if (strobe.hostLoad) begin
      softCnt <= CNT_W'(SOFT_CYC - 1);
    end else if (strobe.ldrLoad) begin
      softCnt <= ldrTwoWire ? CNT_W'(LDR2_CYC - 1) : CNT_W'(LDR3_CYC - 1);
    end else if (strobe.softDec) begin
      softCnt <= softCnt - 1'b1;
    end
  end

  assign softZero = (softCnt == '0);

  for (genvar p = 0; p < PHY_PORTS; p++) begin : g_phyCnt
    logic [CNT_W-1:0] phyCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phyCnt <= '0;
      end else if (strobe.phyLoad[p]) begin
        phyCnt <= CNT_W'(PHY_CYC - 1);
      end else if (strobe.phyDec[p]) begin
        phyCnt <= phyCnt - 1'b1;
      end
    end

    assign phyZero[p] = (phyCnt == '0);
  end

endmodule

// File: rtl/rst_seq_ctl.sv
module rst_seq_ctl
  import rst_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [PHY_PORTS:0]   wrData,
  input  logic [PHY_PORTS-1:0] phyCtlReq,
  input  logic [PHY_PORTS-1:0] phyPwrDn,
  input  logic                 ldrDone,
  input  logic                 softZero,
  input  logic [PHY_PORTS-1:0] phyZero,
  output seqStrobeT            strobe,
  output logic [PHY_PORTS:0]   rdData,
  output logic [PHY_PORTS-1:0] phyRst,
  output logic [PHY_PORTS-1:0] phyRegClr,
  output logic [PHY_PORTS-1:0] phyCtlRstBit,
  output logic                 hostRst,
  output logic                 strapLatch,
  output logic                 ldrStart,
  output logic                 ldrMacOnly
);

  softPhaseT            softPhase, softNext;
  logic                 hostLoad, ldrLoad, softDec;
  logic [PHY_PORTS-1:0] phyBusy, phyKeep, phyViaCtl, pdPrev;
  logic [PHY_PORTS-1:0] phyLoadV, phyDecV, phyRegReq;
  logic                 pwrOnPend, ldrStartQ;

  // Soft reset: host phase, then restricted loader phase.
  always_comb begin
    softNext = softPhase;
    hostLoad = 1'b0;
    ldrLoad  = 1'b0;
    softDec  = 1'b0;
    case (softPhase)
      SOFT_IDLE: begin
        if (wrEn && wrData[0]) begin
          softNext = SOFT_HOST;
          hostLoad = 1'b1;
        end
      end
      SOFT_HOST: begin
        if (softZero) begin
          softNext = SOFT_LOAD;
          ldrLoad  = 1'b1;
        end else begin
          softDec = 1'b1;
        end
      end
      SOFT_LOAD: begin
        if (ldrDone || softZero) begin
          softNext = SOFT_IDLE;
        end else begin
          softDec = 1'b1;
        end
      end
      default: softNext = SOFT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softPhase <= SOFT_IDLE;
      ldrStartQ <= 1'b0;
      pwrOnPend <= 1'b1;
      pdPrev    <= '0;
    end else begin
      softPhase <= softNext;
      ldrStartQ <= ldrLoad;
      pwrOnPend <= 1'b0;
      pdPrev    <= phyPwrDn;
    end
  end

  // Per-port PHY reset: request capture, mode latch, completion.
  for (genvar p = 0; p < PHY_PORTS; p++) begin : g_phyCtl
    logic pdExit;

    assign phyRegReq[p] = (wrEn && wrData[p+1]) || phyCtlReq[p];
    assign pdExit       = pdPrev[p] && !phyPwrDn[p];
    assign phyLoadV[p]  = !phyBusy[p] && (phyRegReq[p] || pdExit);
    assign phyDecV[p]   = phyBusy[p] && !phyZero[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phyBusy[p]   <= 1'b0;
        phyKeep[p]   <= 1'b0;
        phyViaCtl[p] <= 1'b0;
      end else if (phyLoadV[p]) begin
        phyBusy[p]   <= 1'b1;
        phyKeep[p]   <= !phyRegReq[p];
        phyViaCtl[p] <= phyCtlReq[p];
      end else if (phyBusy[p] && phyZero[p]) begin
        phyBusy[p]   <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.hostLoad = hostLoad;
    strobe.ldrLoad  = ldrLoad;
    strobe.softDec  = softDec;
    strobe.phyLoad  = phyLoadV;
    strobe.phyDec   = phyDecV;
  end

  assign hostRst      = (softPhase == SOFT_HOST);
  assign ldrMacOnly   = (softPhase == SOFT_LOAD);
  assign ldrStart     = ldrStartQ;
  assign strapLatch   = pwrOnPend;
  assign phyRst       = phyBusy;
  assign phyRegClr    = phyBusy & ~phyKeep;
  assign phyCtlRstBit = phyBusy & phyViaCtl;
  assign rdData       = {phyBusy, softPhase != SOFT_IDLE};

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int SOFT_US    = 590,
  parameter int LDR_2W_US  = 550,
  parameter int LDR_3W_US  = 170,
  parameter int PHY_US     = 110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [PHY_PORTS:0]   wrData,
  output logic [PHY_PORTS:0]   rdData,
  input  logic [PHY_PORTS-1:0] phyCtlReq,
  input  logic [PHY_PORTS-1:0] phyPwrDn,
  output logic [PHY_PORTS-1:0] phyRst,
  output logic [PHY_PORTS-1:0] phyRegClr,
  output logic [PHY_PORTS-1:0] phyCtlRstBit,
  output logic                 hostRst,
  output logic                 strapLatch,
  output logic                 ldrStart,
  output logic                 ldrMacOnly,
  input  logic                 ldrTwoWire,
  input  logic                 ldrDone
);

  localparam int SOFT_CYC = SOFT_US * CYC_PER_US;
  localparam int LDR2_CYC = LDR_2W_US * CYC_PER_US;
  localparam int LDR3_CYC = LDR_3W_US * CYC_PER_US;
  localparam int PHY_CYC  = PHY_US * CYC_PER_US;
  localparam int MAX_A    = (SOFT_CYC > PHY_CYC) ? SOFT_CYC : PHY_CYC;
  localparam int MAX_B    = (LDR2_CYC > LDR3_CYC) ? LDR2_CYC : LDR3_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seqStrobeT            strobe;
  logic                 softZero;
  logic [PHY_PORTS-1:0] phyZero;

  rst_seq_ctl i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .phyCtlReq    (phyCtlReq),
    .phyPwrDn     (phyPwrDn),
    .ldrDone      (ldrDone),
    .softZero     (softZero),
    .phyZero      (phyZero),
    .strobe       (strobe),
    .rdData       (rdData),
    .phyRst       (phyRst),
    .phyRegClr    (phyRegClr),
    .phyCtlRstBit (phyCtlRstBit),
    .hostRst      (hostRst),
    .strapLatch   (strapLatch),
    .ldrStart     (ldrStart),
    .ldrMacOnly   (ldrMacOnly)
  );

  rst_seq_dp #(
    .SOFT_CYC (SOFT_CYC),
    .LDR2_CYC (LDR2_CYC),
    .LDR3_CYC (LDR3_CYC),
    .PHY_CYC  (PHY_CYC),
    .CNT_W    (CNT_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ldrTwoWire (ldrTwoWire),
    .softZero   (softZero),
    .phyZero    (phyZero)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int SOFT_CYC = 590,
  parameter int PHY_CYC  = 110
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostRst,
  input logic                 ldrStart,
  input logic                 ldrMacOnly,
  input logic                 strapLatch,
  input logic [PHY_PORTS:0]   rdData,
  input logic [PHY_PORTS-1:0] phyRst,
  input logic [PHY_PORTS-1:0] phyRegClr,
  input logic [PHY_PORTS-1:0] phyCtlRstBit
);

  int hostRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hostRun <= 0;
    else if (hostRst) hostRun <= hostRun + 1;
    else              hostRun <= 0;
  end

  AST_HOST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRst && hostRun != 0) |-> (hostRun == SOFT_CYC));  // R1
  AST_LDR_AFTER_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRst) |-> ldrStart);  // R2
  AST_LDR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ldrStart |=> !ldrStart);  // R2
  AST_LDR_RESTRICTED: assert property (@(posedge clk) disable iff (!rstN)
    ldrStart |-> ldrMacOnly);  // R2
  AST_STRAP_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strapLatch |=> !strapLatch);  // R4
  AST_STRAP_NOT_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    hostRst |-> !strapLatch);  // R4
  AST_SOFT_RD: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] == (hostRst || ldrMacOnly));  // R9

  for (genvar p = 0; p < PHY_PORTS; p++) begin : g_phyChk
    int phyRun;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          phyRun <= 0;
      else if (phyRst[p]) phyRun <= phyRun + 1;
      else                phyRun <= 0;
    end

    AST_PHY_LEN: assert property (@(posedge clk) disable iff (!rstN)
      (!phyRst[p] && phyRun != 0) |-> (phyRun == PHY_CYC));  // R5
    AST_PHY_RD: assert property (@(posedge clk) disable iff (!rstN)
      rdData[p+1] == phyRst[p]);  // R9
    AST_CTL_BIT_IN_RST: assert property (@(posedge clk) disable iff (!rstN)
      phyCtlRstBit[p] |-> phyRst[p]);  // R6
    AST_CLR_IN_RST: assert property (@(posedge clk) disable iff (!rstN)
      phyRegClr[p] |-> phyRst[p]);  // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (phyRst[p] && $past(phyRst[p])) |-> ($stable(phyRegClr[p]) && $stable(phyCtlRstBit[p])));  // R8
  end

endmodule

bind rst_seq_ctrl rst_seq_chk #(
  .SOFT_CYC (SOFT_CYC),
  .PHY_CYC  (PHY_CYC)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostRst      (hostRst),
  .ldrStart     (ldrStart),
  .ldrMacOnly   (ldrMacOnly),
  .strapLatch   (strapLatch),
  .rdData       (rdData),
  .phyRst       (phyRst),
  .phyRegClr    (phyRegClr),
  .phyCtlRstBit (phyCtlRstBit)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;

  localparam int CPU  = 1;
  localparam int SOFT = 590 * CPU;
  localparam int L2   = 550 * CPU;
  localparam int L3   = 170 * CPU;
  localparam int PHY  = 110 * CPU;
  localparam int NP   = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [NP:0]   wrData = '0;
  logic [NP:0]   rdData;
  logic [NP-1:0] phyCtlReq = '0;
  logic [NP-1:0] phyPwrDn = '0;
  logic [NP-1:0] phyRst, phyRegClr, phyCtlRstBit;
  logic          hostRst, strapLatch, ldrStart, ldrMacOnly;
  logic          ldrTwoWire = 1'b1;
  logic          ldrDone = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  rst_seq_ctrl #(
    .CYC_PER_US (CPU)
  ) i_rst_seq_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .rdData       (rdData),
    .phyCtlReq    (phyCtlReq),
    .phyPwrDn     (phyPwrDn),
    .phyRst       (phyRst),
    .phyRegClr    (phyRegClr),
    .phyCtlRstBit (phyCtlRstBit),
    .hostRst      (hostRst),
    .strapLatch   (strapLatch),
    .ldrStart     (ldrStart),
    .ldrMacOnly   (ldrMacOnly),
    .ldrTwoWire   (ldrTwoWire),
    .ldrDone      (ldrDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mPhase, mLeft, mStart, mStrap;
  int mPLeft [NP];
  int mKeep  [NP];
  int mVia   [NP];
  int mPdPrev[NP];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mStart = 0; mStrap = 1;
      for (int i = 0; i < NP; i++) begin
        mPLeft[i] = 0; mKeep[i] = 0; mVia[i] = 0; mPdPrev[i] = 0;
      end
    end else begin
      mStrap = 0;
      mStart = 0;
      case (mPhase)
        0: if (wrEn && wrData[0]) begin mPhase = 1; mLeft = SOFT; end
        1: begin
          mLeft--;
          if (mLeft == 0) begin mPhase = 2; mLeft = ldrTwoWire ? L2 : L3; mStart = 1; end
        end
        default: begin
          if (ldrDone) mPhase = 0;
          else begin mLeft--; if (mLeft == 0) mPhase = 0; end
        end
      endcase
      for (int i = 0; i < NP; i++) begin
        automatic bit rq = (wrEn && wrData[i+1]) || phyCtlReq[i];
        automatic bit pd = mPdPrev[i] != 0 && !phyPwrDn[i];
        if (mPLeft[i] == 0) begin
          if (rq || pd) begin
            mPLeft[i] = PHY; mKeep[i] = rq ? 0 : 1; mVia[i] = phyCtlReq[i];
          end
        end else begin
          mPLeft[i]--;
        end
        mPdPrev[i] = phyPwrDn[i];
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1 hostRst", hostRst, mPhase == 1);
      chk("R2/R3 ldrMacOnly", ldrMacOnly, mPhase == 2);
      chk("R2/R5 ldrStart", ldrStart, mStart);
      chk("R4 strapLatch", strapLatch, mStrap);
      chk("R9 rdData soft bit", rdData[0], mPhase != 0);
      for (int i = 0; i < NP; i++) begin
        automatic int busy = mPLeft[i] > 0;
        chk("R5/R8 phyRst", phyRst[i], busy);
        chk("R9 rdData phy bit", rdData[i+1], busy);
        chk("R7 phyRegClr", phyRegClr[i], busy && !mKeep[i]);
        chk("R6 phyCtlRstBit", phyCtlRstBit[i], busy && mVia[i]);
      end
    end
  end

  task automatic wrPulse(input logic [NP:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
      finish();
    end
  end

  initial begin
    int n;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rdData", rdData, 0);
    chk("R10 phyRst", phyRst, 0);
    chk("R10 hostRst", hostRst, 0);
    chk("R10 ldrStart", ldrStart, 0);
    chk("R10 ldrMacOnly", ldrMacOnly, 0);

    // Soft reset, two-wire loader, early done; re-request and zero write mid-way
    wrPulse(3'b001);
    idle(100);
    wrPulse(3'b001);          // R8 ignored
    wrPulse(3'b000);          // R9 no effect
    n = 0;
    while (!ldrStart) begin n++; @(negedge clk); end
    chk("R1 host phase length seen", n + 103, SOFT + 1);
    idle(30);
    ldrDone = 1'b1;
    @(negedge clk);
    ldrDone = 1'b0;
    chk("R3 loader ends after done", ldrMacOnly, 0);
    idle(5);
    chk("R9 rdData after soft", rdData, 0);

    // Soft reset, three-wire loader, no done
    ldrTwoWire = 1'b0;
    wrPulse(3'b001);
    while (!ldrStart) @(negedge clk);
    n = 0;
    while (ldrMacOnly) begin n++; @(negedge clk); end
    chk("R3 three-wire window", n, L3);
    ldrTwoWire = 1'b1;
    idle(5);

    // PHY resets through both paths, with ignored re-requests
    wrPulse(3'b010);
    idle(40);
    phyCtlReq = 2'b10; @(negedge clk); phyCtlReq = 2'b00;
    idle(20);
    wrPulse(3'b010);          // R8 ignored, port 0 busy
    phyCtlReq = 2'b01; @(negedge clk); phyCtlReq = 2'b00;  // R8 ignored
    chk("R5 soft untouched by PHY", hostRst, 0);
    idle(150);
    chk("R6 all clear after PHY resets", {phyCtlRstBit, rdData}, 0);

    // Power-down exit, and exit on a busy port
    phyPwrDn = 2'b10;
    idle(5);
    phyPwrDn = 2'b00;
    idle(3);
    chk("R7 pd exit reset", phyRst[1], 1);
    chk("R7 pd exit keeps regs", phyRegClr[1], 0);
    wrPulse(3'b010);
    phyPwrDn[0] = 1'b1;
    idle(10);
    phyPwrDn[0] = 1'b0;       // R8 busy port ignores exit
    idle(130);

    // Power-down exit and control request together: register path wins
    phyPwrDn = 2'b10;
    idle(4);
    phyPwrDn = 2'b00;
    phyCtlReq = 2'b10;
    @(negedge clk);
    phyCtlReq = 2'b00;
    idle(2);
    chk("R7 register path wins", phyRegClr[1], 1);
    idle(120);

    // All three domains at once, loader times out on two-wire bus
    wrPulse(3'b111);
    idle(PHY + 5);
    chk("R8 PHY done while soft runs", {rdData[2:1], rdData[0]}, 1);
    idle(SOFT + L2);
    chk("R9 all idle", rdData, 0);
    chk("R4 no strap after soft", strapLatch, 0);
    finish();
  end

endmodule